// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a circular list of transmit descriptors kept in system memory. Software first sets the ring start address. It then pulses the activate input while the controller enable is high. The walker fetches each descriptor in turn through a request/acknowledge memory port. It streams the buffer that the descriptor points to, one byte at a time, onto a ready/valid byte output toward the MAC. It then writes the descriptor back with its ready flag cleared and moves on to the next entry. A pass ends at the first descriptor that is not ready, and the walker keeps that descriptor as its resume point.

Each descriptor occupies 8 bytes. The word at the descriptor address holds the length in bits [15:0] and the flags in bits [31:16]. The word at address + 4 holds the byte address of the buffer. The flags are: ready = word bit 31, wrap = word bit 29, last = word bit 27. Pulsed events mark each consumed descriptor, each completed frame and each frame that grows past the 2047-byte limit.

The controller is a single state machine:
- States: S_IDLE, S_FETCH_CTL, S_FETCH_PTR, S_FETCH_DATA, S_EMIT, S_WRITEBACK.
- Transitions: IDLE→FETCH_CTL on an enabled activation or a held one. FETCH_CTL→FETCH_PTR when the ready flag is set, and FETCH_CTL→IDLE when it is clear. FETCH_PTR→FETCH_DATA when there are bytes to copy, and FETCH_PTR→WRITEBACK when there are none. FETCH_DATA→EMIT once the word arrives. EMIT→FETCH_DATA while bytes remain, and EMIT→WRITEBACK on the final byte. WRITEBACK→FETCH_CTL once the write is acknowledged.

Top module: `txr_engine`

## Requirements
- R1: After reset, mem_req, tx_valid and all three event outputs are low.
- R2: While ctrl_en is low, an activate pulse issues no memory request.
- R3: A descriptor whose ready flag (word bit 31) is clear ends the pass. The next activation reads that same descriptor address first.
- R4: Buffer bytes leave on tx_data in address order. Byte address a is taken from word a&~3 at bits [8*(a%4)+7 : 8*(a%4)]. tx_data stays stable while tx_valid is high and tx_ready is low.
- R5: Each consumed descriptor is written back to its first word with bit 31 cleared. Length and the other flag bits are unchanged. The memory address and request stay stable until acknowledged.
- R6: evt_buf_done pulses once per consumed descriptor. evt_frame_done pulses with it when the last flag (word bit 27) is set.
- R7: After a descriptor with the wrap flag (word bit 29) set, the next descriptor is read from the ring start. Otherwise it is read from the current address + 8.
- R8: When the bytes already in the frame plus the descriptor length exceed 2047, only 2047 minus the bytes already in the frame are copied and evt_babble pulses. The frame byte count restarts at zero after a last descriptor.
- R9: Writing the ring start ignores address bits [1:0] and also moves the current descriptor pointer to the new start.
- R10: An enabled activation that arrives during a pass is held. A new pass starts after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller enable; gates activation |
| activate | input | 1 | One-cycle request to walk the ring |
| ring_base_we | input | 1 | Ring start write strobe |
| ring_base_wdata | input | 32 | Ring start address |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Frame byte available |
| tx_data | output | 8 | Frame byte |
| tx_ready | input | 1 | MAC accepts the byte |
| evt_buf_done | output | 1 | Descriptor consumed pulse |
| evt_frame_done | output | 1 | Frame completed pulse |
| evt_babble | output | 1 | Frame size limit exceeded pulse |

## Verification
A wrong resume pointer shows up on the very next activation: the first memory read goes to an unexpected address. A wrong frame byte counter appears only at the following over-length frame, as a missing or extra babble pulse and a wrong number of bytes on tx_data. A corrupted buffer pointer or byte lane shows up on the first mismatched tx_data byte, in the cycle that byte is accepted. A bad write-back word is seen in memory as soon as the pass ends.

// File: rtl/txr_pkg.sv
package txr_pkg;
    // flag bit positions inside the 16-bit flags half-word
    localparam int FLAG_READY = 15;
    localparam int FLAG_WRAP  = 13;
    localparam int FLAG_LAST  = 11;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_CTL,
        S_FETCH_PTR,
        S_FETCH_DATA,
        S_EMIT,
        S_WRITEBACK
    } state_t;
endpackage

// File: rtl/txr_len_clip.sv
module txr_len_clip #(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 2047
) (
    input  logic [LEN_W-1:0] acc,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] take,
    output logic             over
);
    logic [LEN_W:0] sum;

    always_comb begin
        sum  = {1'b0, acc} + {1'b0, len};
        over = sum > (LEN_W+1)'(MAX_FRAME);
        take = over ? (LEN_W'(MAX_FRAME) - acc) : len;
    end
endmodule

// File: rtl/txr_byte_pick.sv
module txr_byte_pick #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]                 word,
    input  logic [$clog2(DATA_W/8)-1:0]       lane,
    output logic [7:0]                        byte_out
);
    always_comb byte_out = word[8*lane +: 8];
endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] cur
);
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur    <= '0;
        end else if (base_we) begin
            base_q <= base_wdata & ~ADDR_W'(3);
            cur    <= base_wdata & ~ADDR_W'(3);
        end else if (advance) begin
            cur <= wrap ? base_q : cur + ADDR_W'(DESC_BYTES);
        end
    end
endmodule

// File: rtl/txr_engine.sv
module txr_engine
    import txr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int MAX_FRAME  = 2047,
    parameter int DESC_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              activate,
    input  logic              ring_base_we,
    input  logic [ADDR_W-1:0] ring_base_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              evt_buf_done,
    output logic              evt_frame_done,
    output logic              evt_babble
);
    localparam int DATA_W = 32;
    localparam int LANE_W = $clog2(DATA_W/8);

    state_t            state, state_nx;
    logic [15:0]       flags_q;
    logic [LEN_W-1:0]  len_q, cnt_q, acc_q, take;
    logic [ADDR_W-1:0] bufp_q, cur;
    logic [7:0]        byte_q, picked;
    logic              pend_q, over, go, advance;

    txr_len_clip #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) i_clip (
        .acc(acc_q), .len(len_q), .take(take), .over(over));

    txr_byte_pick #(.DATA_W(DATA_W)) i_pick (
        .word(mem_rdata), .lane(bufp_q[LANE_W-1:0]), .byte_out(picked));

    txr_ring_ptr #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) i_ptr (
        .clk(clk), .rst_n(rst_n), .base_we(ring_base_we),
        .base_wdata(ring_base_wdata), .advance(advance),
        .wrap(flags_q[FLAG_WRAP]), .cur(cur));

    assign go      = ctrl_en && (activate || pend_q);
    assign advance = (state == S_WRITEBACK) && mem_ack;

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:       if (go) state_nx = S_FETCH_CTL;
            S_FETCH_CTL:  if (mem_ack)
                              state_nx = mem_rdata[16+FLAG_READY] ? S_FETCH_PTR : S_IDLE;
            S_FETCH_PTR:  if (mem_ack)
                              state_nx = (take == '0) ? S_WRITEBACK : S_FETCH_DATA;
            S_FETCH_DATA: if (mem_ack) state_nx = S_EMIT;
            S_EMIT:       if (tx_ready)
                              state_nx = (cnt_q == LEN_W'(1)) ? S_WRITEBACK : S_FETCH_DATA;
            S_WRITEBACK:  if (mem_ack) state_nx = S_FETCH_CTL;
            default:      state_nx = S_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            flags_q <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            acc_q   <= '0;
            bufp_q  <= '0;
            byte_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE)
                pend_q <= 1'b0;
            else if (activate && ctrl_en)
                pend_q <= 1'b1;
            unique case (state)
                S_FETCH_CTL: if (mem_ack) begin
                    flags_q <= mem_rdata[31:16];
                    len_q   <= mem_rdata[LEN_W-1:0];
                end
                S_FETCH_PTR: if (mem_ack) begin
                    bufp_q <= mem_rdata;
                    cnt_q  <= take;
                    acc_q  <= acc_q + take;
                end
                S_FETCH_DATA: if (mem_ack) byte_q <= picked;
                S_EMIT: if (tx_ready) begin
                    bufp_q <= bufp_q + ADDR_W'(1);
                    cnt_q  <= cnt_q - LEN_W'(1);
                end
                S_WRITEBACK: if (mem_ack && flags_q[FLAG_LAST]) acc_q <= '0;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req        = 1'b0;
        mem_we         = 1'b0;
        mem_addr       = cur;
        mem_wdata      = {flags_q & ~(16'd1 << FLAG_READY), len_q};
        tx_valid       = 1'b0;
        tx_data        = byte_q;
        evt_buf_done   = 1'b0;
        evt_frame_done = 1'b0;
        evt_babble     = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_FETCH_CTL:  mem_req = 1'b1;
            S_FETCH_PTR: begin
                mem_req    = 1'b1;
                mem_addr   = cur + ADDR_W'(DESC_BYTES/2);
                evt_babble = mem_ack && over;
            end
            S_FETCH_DATA: begin
                mem_req  = 1'b1;
                mem_addr = bufp_q & ~ADDR_W'(3);
            end
            S_EMIT:       tx_valid = 1'b1;
            S_WRITEBACK: begin
                mem_req        = 1'b1;
                mem_we         = 1'b1;
                evt_buf_done   = mem_ack;
                evt_frame_done = mem_ack && flags_q[FLAG_LAST];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_ready,
    input logic              evt_buf_done,
    input logic              evt_frame_done,
    input logic              evt_babble
);
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_req && !tx_valid && !evt_buf_done && !evt_frame_done && !evt_babble);

    p_byte_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_writeback_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]);

    p_frame_with_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_frame_done |-> evt_buf_done);

    p_babble_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_babble |-> mem_ack && !mem_we && !evt_buf_done);
endmodule

bind txr_engine txr_engine_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .evt_buf_done(evt_buf_done), .evt_frame_done(evt_frame_done),
    .evt_babble(evt_babble));

// File: tb/test_txr_engine.sv
module test_txr_engine;
    localparam logic [15:0] F_READY = 16'h8000;
    localparam logic [15:0] F_WRAP  = 16'h2000;
    localparam logic [15:0] F_LAST  = 16'h0800;

    logic clk = 1'b0, rst_n = 1'b0, ctrl_en = 1'b0, activate = 1'b0;
    logic ring_base_we = 1'b0;
    logic [31:0] ring_base_wdata = '0;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic tx_valid, tx_ready = 1'b1;
    logic [7:0] tx_data;
    logic evt_buf_done, evt_frame_done, evt_babble;

    txr_engine i_txr_engine (.*);

    always #10 clk = ~clk;

    logic [31:0] mem [logic [31:0]];
    logic [7:0]  exp_q [$];
    logic [31:0] rdlog [$];
    int n_chk = 0, n_fail = 0, n_buf = 0, n_frame = 0, n_bab = 0, cyc = 0;
    bit stall_mode = 1'b0, done = 1'b0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic void put_byte(input logic [31:0] a, input logic [7:0] v);
        logic [31:0] w;
        w = rd({a[31:2], 2'b00});
        w[8*a[1:0] +: 8] = v;
        mem[{a[31:2], 2'b00}] = w;
    endfunction

    function automatic void chk(input bit ok, input string req, input string what,
                                input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endfunction

    // place a descriptor, fill its buffer and record the bytes the model expects
    function automatic void put_desc(input logic [31:0] d, input logic [15:0] fl,
                                     input int len, input logic [31:0] b,
                                     input int send, input logic [7:0] seed);
        mem[d]     = {fl, 16'(len)};
        mem[d + 4] = b;
        for (int i = 0; i < len; i++) put_byte(b + i, seed + 8'(i * 7));
        for (int i = 0; i < send; i++) exp_q.push_back(seed + 8'(i * 7));
    endfunction

    function automatic int count_reads(input logic [31:0] a);
        int n = 0;
        foreach (rdlog[i]) if (rdlog[i] == a) n++;
        return n;
    endfunction

    // memory responder at +5 ns, observer at +15 ns after each rising edge
    always begin
        @(posedge clk);
        #5;
        tx_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            mem_ack = 1'b1;
            if (mem_we) mem[mem_addr] = mem_wdata;
            else mem_rdata = rd(mem_addr);
        end
        #10;
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected byte", 32'(tx_data), 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(tx_data == e, "R4", "byte", 32'(tx_data), 32'(e));
                end
            end
            if (mem_req && mem_ack && !mem_we) rdlog.push_back(mem_addr);
            if (evt_buf_done) n_buf++;
            if (evt_frame_done) n_frame++;
            if (evt_babble) n_bab++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic pulse_act();
        @(negedge clk) activate = 1'b1;
        @(negedge clk) activate = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            quiet = (mem_req || tx_valid) ? 0 : quiet + 1;
        end
    endtask

    task automatic set_base(input logic [31:0] a);
        @(negedge clk) begin ring_base_we = 1'b1; ring_base_wdata = a; end
        @(negedge clk) ring_base_we = 1'b0;
    endtask

    task automatic clear_stats();
        n_buf = 0; n_frame = 0; n_bab = 0; rdlog.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!mem_req && !tx_valid, "R1", "idle outputs", {30'd0, mem_req, tx_valid}, 0);
        chk(!evt_buf_done && !evt_frame_done && !evt_babble, "R1", "events",
            {29'd0, evt_buf_done, evt_frame_done, evt_babble}, 0);

        // R2: activation with enable low
        set_base(32'h100);
        put_desc(32'h100, F_READY, 5, 32'h1001, 0, 8'h10);
        pulse_act();
        repeat (10) @(negedge clk);
        chk(rdlog.size() == 0, "R2", "reads while disabled", rdlog.size(), 0);

        // R3 R4 R5 R6: two-descriptor frame, stop on not-ready entry
        ctrl_en = 1'b1;
        exp_q.delete(); clear_stats();
        put_desc(32'h100, F_READY, 5, 32'h1001, 5, 8'h10);
        put_desc(32'h108, F_READY | F_LAST, 3, 32'h2003, 3, 8'h40);
        mem[32'h110] = 32'h0;
        pulse_act(); wait_idle();
        chk(exp_q.size() == 0, "R4", "bytes left", exp_q.size(), 0);
        chk(n_buf == 2, "R6", "buffer events", n_buf, 2);
        chk(n_frame == 1, "R6", "frame events", n_frame, 1);
        chk(rd(32'h100) == 32'h0000_0005, "R5", "writeback d0", rd(32'h100), 32'h0000_0005);
        chk(rd(32'h108) == 32'h0800_0003, "R5", "writeback d1", rd(32'h108), 32'h0800_0003);
        chk(rdlog[rdlog.size()-1] == 32'h110, "R3", "stop address", rdlog[rdlog.size()-1], 32'h110);
        clear_stats();
        pulse_act(); wait_idle();
        chk(rdlog.size() == 1 && rdlog[0] == 32'h110, "R3", "resume address", rdlog[0], 32'h110);

        // R7: wrap back to ring start
        clear_stats();
        put_desc(32'h110, F_READY | F_WRAP | F_LAST, 2, 32'h3000, 2, 8'h80);
        pulse_act(); wait_idle();
        chk(exp_q.size() == 0, "R7", "wrap bytes left", exp_q.size(), 0);
        chk(rdlog[rdlog.size()-1] == 32'h100, "R7", "wrap target", rdlog[rdlog.size()-1], 32'h100);

        // R8 R9: oversize frame truncated, then a fresh frame, under backpressure
        set_base(32'h4003);
        clear_stats(); stall_mode = 1'b1;
        put_desc(32'h4000, F_READY, 2000, 32'h10000, 2000, 8'h01);
        put_desc(32'h4008, F_READY | F_LAST, 100, 32'h20002, 47, 8'h33);
        put_desc(32'h4010, F_READY | F_LAST | F_WRAP, 4, 32'h30001, 4, 8'h55);
        pulse_act(); wait_idle();
        stall_mode = 1'b0;
        chk(rdlog[0] == 32'h4000, "R9", "first read after base write", rdlog[0], 32'h4000);
        chk(exp_q.size() == 0, "R8", "bytes left", exp_q.size(), 0);
        chk(n_bab == 1, "R8", "babble events", n_bab, 1);
        chk(n_frame == 2, "R8", "frames", n_frame, 2);
        chk(n_buf == 3, "R6", "buffer events", n_buf, 3);
        chk(rd(32'h4008) == 32'h0800_0064, "R5", "writeback length kept", rd(32'h4008), 32'h0800_0064);
        chk(rdlog[rdlog.size()-1] == 32'h4000, "R7", "wrap target", rdlog[rdlog.size()-1], 32'h4000);

        // R10: activation during a pass is held
        set_base(32'h5000);
        clear_stats();
        put_desc(32'h5000, F_READY | F_LAST, 6, 32'h5100, 6, 8'h20);
        mem[32'h5008] = 32'h0;
        pulse_act();
        repeat (3) @(negedge clk);
        pulse_act(); wait_idle();
        chk(count_reads(32'h5008) == 2, "R10", "held pass reads", count_reads(32'h5008), 2);
        chk(exp_q.size() == 0 && n_frame == 1, "R10", "frames", n_frame, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule